// File: doc/BRIEF.md
# Sticky Clear-on-Read Interrupt Status

This block collects seven event sources of a digital audio receiver into one 8-bit status word for a host. Each source latches into its own bit, which stays at 1 until the host reads the word. The sources are a format change, a new subcode block, a receiver error, a channel-status change, a buffer transfer, an output sample slip, and a preamble-byte change. A per-bit enable mask gates both the latching and the read data. A single request output flags that any enabled bit is set.

Two of the bits come from a five-flag format-detect vector. The block keeps a registered copy of that vector, so it can find flags that go from 0 to 1. A mode input selects how a bit behaves. In edge mode a bit is set only on a rising edge of its source. In level mode a bit is set on every cycle its source is true, so it survives a read while the condition lasts.

Top module: `audio_irq_status`

## Requirements
- R1: A set bit stays at 1 through any number of cycles without a read strobe, whatever its source does afterwards.
- R2: While `rd_i` is high, `rdata_o` shows the value held before the clear. The clear takes effect on the clock edge that ends the read cycle.
- R3: A bit whose `mask_i` bit is 0 reads 0. An event arriving while its mask bit is 0 is not latched. Clearing a mask bit hides a bit that is already set.
- R4: Status bit 0 (format change) is set when any bit of `fmt_i[4:0]` goes from 0 to 1. A flag going from 1 to 0 never sets it.
- R5: Status bit 6 (preamble change) is set by `pc_chg_i`. It is also set by every 0-to-1 transition of `fmt_i[1]`, the compressed-format flag, even when no preamble event occurs.
- R6: The bit positions are fixed. Bit 0 is format change, 1 is subcode ready, 2 is receiver error, 3 is channel-status change, 4 is buffer transfer, 5 is sample slip and 6 is preamble change. Bit 7 always reads 0.
- R7: In level mode (`level_mode_i`=1), a bit whose source is still high at a read stays at 1 after it. Once the source is low at a read, the bit clears.
- R8: In edge mode (`level_mode_i`=0), a source held high sets its bit only once. After a read the bit stays at 0 until the source falls and rises again.
- R9: An event that arrives in the same cycle as the read strobe is not lost. Its bit reads 0 in that read and 1 on the next read.
- R10: `irq_o` is 1 exactly when at least one enabled status bit is 1.
- R11: Reset clears every status bit and the stored format-flag history. A flag held high through reset therefore counts as a 0-to-1 transition in the first cycle after reset.
- R12: Each sample slip pulse sets the slip bit again after a read has cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 5 | Format-detect flags; bit 1 is the compressed-format flag |
| qsub_rdy_i | input | 1 | New subcode block event |
| rx_err_i | input | 1 | Receiver error event |
| cs_chg_i | input | 1 | Channel-status change event |
| xfer_i | input | 1 | Buffer transfer event |
| slip_i | input | 1 | Output sample dropped or repeated, one pulse per sample |
| pc_chg_i | input | 1 | Preamble byte value changed |
| mask_i | input | 7 | Per-bit enable, 1 enables the bit |
| level_mode_i | input | 1 | 1 selects level mode, 0 selects edge mode |
| rd_i | input | 1 | Read strobe; clears the status at the end of the cycle |
| rdata_o | output | 8 | Masked status word |
| irq_o | output | 1 | Any enabled status bit set |

## Verification
The hardest cases to reach are those where a read and a source meet in the same cycle. One is an event arriving in the read cycle itself. The other is a level-mode source that is still high when the clear lands. The stimulus drives the event and the read strobe on the same falling edge, and then reads a second time to show the bit survived. It also holds a level source high across two reads and then drops it before a third and fourth read. Edge mode is run through the same held-source sequence, to show that only one latch happens there.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned STAT_W  = 8;

  localparam int unsigned BIT_FMT   = 0;
  localparam int unsigned BIT_QSUB  = 1;
  localparam int unsigned BIT_RXERR = 2;
  localparam int unsigned BIT_CSCHG = 3;
  localparam int unsigned BIT_XFER  = 4;
  localparam int unsigned BIT_SLIP  = 5;
  localparam int unsigned BIT_PCCHG = 6;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/fmt_edge_detect.sv
module fmt_edge_detect #(
  parameter int unsigned NUM_FMT = 5,
  parameter int unsigned CMP_IDX = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_FMT-1:0] fmt_i,
  output logic               any_rise_o,
  output logic               cmp_rise_o
);
  logic [NUM_FMT-1:0] fmt_q;
  logic [NUM_FMT-1:0] rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmt_q <= '0;
    else         fmt_q <= fmt_i;
  end

  assign rise       = fmt_i & ~fmt_q;
  assign any_rise_o = |rise;
  assign cmp_rise_o = rise[CMP_IDX];
endmodule

// File: rtl/irq_source_map.sv
module irq_source_map
  import audio_irq_pkg::*;
(
  input  logic     fmt_rise_i,
  input  logic     cmp_rise_i,
  input  logic     qsub_rdy_i,
  input  logic     rx_err_i,
  input  logic     cs_chg_i,
  input  logic     xfer_i,
  input  logic     slip_i,
  input  logic     pc_chg_i,
  output src_vec_t src_o
);
  always_comb begin
    src_o            = '0;
    src_o[BIT_FMT]   = fmt_rise_i;
    src_o[BIT_QSUB]  = qsub_rdy_i;
    src_o[BIT_RXERR] = rx_err_i;
    src_o[BIT_CSCHG] = cs_chg_i;
    src_o[BIT_XFER]  = xfer_i;
    src_o[BIT_SLIP]  = slip_i;
    // compressed-format onset also forces a preamble report
    src_o[BIT_PCCHG] = pc_chg_i | cmp_rise_i;
  end
endmodule

// File: rtl/irq_sticky_cell.sv
module irq_sticky_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic en_i,
  input  logic level_i,
  input  logic clr_i,
  output logic bit_o
);
  logic prev_q;
  logic bit_q;
  logic set;

  assign set = en_i & (level_i ? src_i : (src_i & ~prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      prev_q <= src_i;
      // set wins over clear so a coincident event survives the read
      bit_q  <= (clr_i ? 1'b0 : bit_q) | set;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/audio_irq_status.sv
module audio_irq_status
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_FMT = 5,
  parameter int unsigned CMP_IDX = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_FMT-1:0] fmt_i,
  input  logic               qsub_rdy_i,
  input  logic               rx_err_i,
  input  logic               cs_chg_i,
  input  logic               xfer_i,
  input  logic               slip_i,
  input  logic               pc_chg_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               level_mode_i,
  input  logic               rd_i,
  output logic [STAT_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic     fmt_rise;
  logic     cmp_rise;
  src_vec_t src_w;
  src_vec_t sticky;
  src_vec_t visible;

  fmt_edge_detect #(
    .NUM_FMT(NUM_FMT),
    .CMP_IDX(CMP_IDX)
  ) u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fmt_i     (fmt_i),
    .any_rise_o(fmt_rise),
    .cmp_rise_o(cmp_rise)
  );

  irq_source_map u_map (
    .fmt_rise_i(fmt_rise),
    .cmp_rise_i(cmp_rise),
    .qsub_rdy_i(qsub_rdy_i),
    .rx_err_i  (rx_err_i),
    .cs_chg_i  (cs_chg_i),
    .xfer_i    (xfer_i),
    .slip_i    (slip_i),
    .pc_chg_i  (pc_chg_i),
    .src_o     (src_w)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    irq_sticky_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_w[g]),
      .en_i   (mask_i[g]),
      .level_i(level_mode_i),
      .clr_i  (rd_i),
      .bit_o  (sticky[g])
    );
  end

  assign visible = sticky & mask_i;
  assign rdata_o = {{(STAT_W-NUM_SRC){1'b0}}, visible};
  assign irq_o   = |visible;
endmodule

// File: rtl/audio_irq_status_chk.sv
module audio_irq_status_chk
  import audio_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] mask_i,
  input logic               level_mode_i,
  input logic               rd_i,
  input logic [NUM_SRC-1:0] src_i,
  input logic [STAT_W-1:0]  rdata_o,
  input logic               irq_o
);
  // R6
  a_r6_top_bit_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[STAT_W-1:NUM_SRC] == '0);

  // R3
  a_r3_masked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[NUM_SRC-1:0] & ~mask_i) == '0);

  // R10
  a_r10_irq_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (rdata_o != '0));

  // R2
  a_r2_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && src_i == '0) |=> rdata_o == '0);

  // R1
  a_r1_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (!$stable(mask_i) ||
      ((rdata_o & $past(rdata_o)) == $past(rdata_o))));

  // R7, R9
  a_r7_level_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_mode_i && (src_i & mask_i) != '0) |=> (!$stable(mask_i) ||
      ((rdata_o[NUM_SRC-1:0] & $past(src_i & mask_i)) == $past(src_i & mask_i))));
endmodule

bind audio_irq_status audio_irq_status_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mask_i      (mask_i),
  .level_mode_i(level_mode_i),
  .rd_i        (rd_i),
  .src_i       (src_w),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o)
);

// File: tb/audio_irq_status_tb.sv
module audio_irq_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fmt = '0;
  logic [5:0] ev = '0;  // qsub, rxerr, cschg, xfer, slip, pcchg -> bits 1..6
  logic [6:0] mask = 7'h7f;
  logic       level = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0;
  int         n_err = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  audio_irq_status u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fmt_i       (fmt),
    .qsub_rdy_i  (ev[0]),
    .rx_err_i    (ev[1]),
    .cs_chg_i    (ev[2]),
    .xfer_i      (ev[3]),
    .slip_i      (ev[4]),
    .pc_chg_i    (ev[5]),
    .mask_i      (mask),
    .level_mode_i(level),
    .rd_i        (rd),
    .rdata_o     (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] val);
    @(negedge clk);
    rd = 1'b1;
    #1 val = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev[idx] = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    #1 check("R11 reset rdata", rdata, 8'h00);
    check("R11 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_order;
    for (int i = 0; i < 6; i++) begin
      pulse(i);
      do_read(v);
      check("R6 bit position", v, 8'h01 << (i + 1));
    end
    @(negedge clk);
    fmt[4] = 1'b1;
    do_read(v);
    check("R6 format bit 0", v, 8'h01);
    fmt[4] = 1'b0;
    do_read(v);
  endtask

  task automatic t_sticky;
    pulse(1);
    idle(5);
    #1 check("R1 held without read", rdata, 8'h04);
    do_read(v);
    check("R2 read returns pre-clear", v, 8'h04);
    #1 check("R2 cleared after read", rdata, 8'h00);
  endtask

  task automatic t_slip;
    for (int k = 0; k < 3; k++) begin
      pulse(4);
      do_read(v);
      check("R12 slip re-set", v, 8'h20);
    end
  endtask

  task automatic t_fmt;
    @(negedge clk);
    fmt[3] = 1'b1;
    do_read(v);
    check("R4 rise sets format bit", v, 8'h01);
    @(negedge clk);
    fmt[3] = 1'b0;
    idle(2);
    do_read(v);
    check("R4 fall does not set", v, 8'h00);
    @(negedge clk);
    fmt[1] = 1'b1;
    do_read(v);
    check("R5 compressed rise sets bits 0 and 6", v, 8'h41);
    fmt[1] = 1'b0;
    idle(2);
    do_read(v);
    check("R5 compressed fall sets nothing", v, 8'h00);
    fmt[1] = 1'b1;
    do_read(v);
    check("R5 second compressed rise", v, 8'h41);
    fmt[1] = 1'b0;
    idle(2);
  endtask

  task automatic t_mask;
    @(negedge clk);
    mask = 7'h7b;
    pulse(1);
    #1 check("R3 masked event reads 0", rdata, 8'h00);
    check("R10 masked irq low", {7'd0, irq}, 8'h00);
    mask = 7'h7f;
    #1 check("R3 masked event not latched", rdata, 8'h00);
    pulse(2);
    #1 check("R10 irq high", {7'd0, irq}, 8'h01);
    mask = 7'h77;
    #1 check("R3 mask hides set bit", rdata, 8'h00);
    check("R10 irq follows mask", {7'd0, irq}, 8'h00);
    mask = 7'h7f;
    do_read(v);
  endtask

  task automatic t_level;
    @(negedge clk);
    level = 1'b1;
    ev[1] = 1'b1;
    do_read(v);
    check("R7 level first read", v, 8'h04);
    do_read(v);
    check("R7 level source still high", v, 8'h04);
    ev[1] = 1'b0;
    do_read(v);
    check("R7 level last read", v, 8'h04);
    do_read(v);
    check("R7 level cleared", v, 8'h00);
    level = 1'b0;
  endtask

  task automatic t_edge;
    @(negedge clk);
    ev[3] = 1'b1;
    do_read(v);
    check("R8 edge first read", v, 8'h10);
    do_read(v);
    check("R8 held source no re-set", v, 8'h00);
    idle(3);
    #1 check("R8 still clear", rdata, 8'h00);
    ev[3] = 1'b0;
    idle(1);
  endtask

  task automatic t_coincide;
    @(negedge clk);
    ev[2] = 1'b1;
    rd = 1'b1;
    #1 v = rdata;
    check("R9 coincident read", v, 8'h00);
    @(negedge clk);
    ev[2] = 1'b0;
    rd = 1'b0;
    do_read(v);
    check("R9 coincident event kept", v, 8'h08);
  endtask

  task automatic t_reset_hist;
    @(negedge clk);
    pulse(0);
    fmt[2] = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R11 reset clears status", rdata, 8'h00);
    idle(2);
    rst_n = 1'b1;
    idle(1);
    #1 check("R11 history cleared", rdata, 8'h01);
    fmt[2] = 1'b0;
    do_read(v);
  endtask

  initial begin
    t_reset();
    idle(2);
    rst_n = 1'b1;
    idle(2);
    t_order();
    t_sticky();
    t_slip();
    t_fmt();
    t_mask();
    t_level();
    t_edge();
    t_coincide();
    t_reset_hist();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule